// File: doc/BRIEF.md
# Device Register Decoder With Test Registers

This block is the 32-bit register slave that sits behind an 8 KB device register window. It decodes a byte address down to a 32-bit word. It holds a small set of registers that software uses to bring the device up and to exercise the register path:

- a marker region that catches stray accesses;
- two loopback registers that answer with double the stored value;
- a register that fires an interrupt request on demand;
- a 64-bit port-enable mask;
- a 64-bit view of per-port link state;
- a write-only control word that issues a device reset;
- a read-only count of front-panel ports.

A host issues one access per cycle on a valid/ready bus. Ready is always high, so every request is accepted in the cycle it is presented. Read data returns on a response strobe one cycle later. A 64-bit register is reached through two word accesses: the word at the base offset holds bits 31:0 and the word at base+4 holds bits 63:32. A write to the lower word only loads a holding register. The whole 64-bit value changes when the upper word is written. The port-enable mask drives a vector of enables. The control word and the interrupt register turn into one-cycle pulses.

Top module: `devreg_bank`

## Requirements
- R1: Byte offsets 0x000 to 0x00F read as 0xDEADBABE, and writes to them change no register or output.
- R2: Any offset that is not mapped reads as 0, and writes to it change no register or output.
- R3: The 32-bit loopback register at 0x010 reads as twice the last value written, modulo 2^32.
- R4: For the 64-bit registers, a write to the lower word (0x018, 0x318) is held and changes nothing visible. A write to the upper word (0x01C, 0x31C) commits {upper data, most recent lower data}, even when no lower write came just before it.
- R5: The 64-bit loopback register reads as twice its committed value, modulo 2^64. Bits 31:0 of the doubled value are at 0x018 and bits 63:32 are at 0x01C.
- R6: A write to 0x020 makes irq_pulse high for exactly the next cycle, with irq_vec equal to bits 7:0 of the written data. Reading 0x020 returns that vector.
- R7: The port-enable mask (0x318 low word, 0x31C high word) resets to 0 and drives port_en. Its bits 0 and 63 always read 0 and are never driven high.
- R8: Reading 0x310 and 0x314 returns the low and high words of link_up, with bits 0 and 63 forced to 0.
- R9: A write to 0x300 with bit 0 set makes soft_rst high for exactly the next cycle. With bit 0 clear, no pulse occurs. The word always reads 0.
- R10: Offset 0x304 reads the parameter NUM_PORTS.
- R11: bus_ready is always 1. A read accepted in one cycle gives rsp_valid high, with rsp_rdata, in the next cycle only. A write never raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (13) | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| link_up | input | 64 | Per-port link state |
| port_en | output | 64 | Port enable mask |
| soft_rst | output | 1 | One-cycle device reset request |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | VEC_W (8) | Vector of the last interrupt request |

## Verification
The assertions take some things for granted about the inputs:

- bus_valid is low while reset is held;
- every request is a single-cycle, word-aligned access;
- each valid cycle is one complete request.

If any of these fail, the checks that link a pulse or a response to the request in the previous cycle lose their meaning. The stimulus keeps within these limits. It drives each request for exactly one cycle, away from the clock edge, and only after reset has been released. It uses only word-aligned offsets, and it keeps link_up steady while a link-status read is in flight.

// File: rtl/devreg_pkg.sv
package devreg_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_GUARD,
        SEL_T32,
        SEL_T64_LO,
        SEL_T64_HI,
        SEL_IRQ,
        SEL_CTRL,
        SEL_PCOUNT,
        SEL_LINK_LO,
        SEL_LINK_HI,
        SEL_PEN_LO,
        SEL_PEN_HI
    } reg_sel_e;

    localparam logic [31:0] GUARD_MARK = 32'hDEAD_BABE;

    // byte offsets of the word registers
    localparam logic [15:0] OFS_GUARD_END = 16'h0010;
    localparam logic [15:0] OFS_T32       = 16'h0010;
    localparam logic [15:0] OFS_T64       = 16'h0018;
    localparam logic [15:0] OFS_IRQ       = 16'h0020;
    localparam logic [15:0] OFS_CTRL      = 16'h0300;
    localparam logic [15:0] OFS_PCOUNT    = 16'h0304;
    localparam logic [15:0] OFS_LINK      = 16'h0310;
    localparam logic [15:0] OFS_PEN       = 16'h0318;

    // bits 0 and 63 of the port masks are never live
    localparam logic [63:0] PORT_LIVE_MASK = 64'h7FFF_FFFF_FFFF_FFFE;

endpackage

// File: rtl/devreg_decode.sv
module devreg_decode
    import devreg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    logic [15:0] base;

    always_comb begin
        base = 16'({addr[ADDR_W-1:2], 2'b00});
        sel  = SEL_NONE;
        if (base < OFS_GUARD_END) begin
            sel = SEL_GUARD;
        end else begin
            unique case (base)
                OFS_T32:           sel = SEL_T32;
                OFS_T64:           sel = SEL_T64_LO;
                OFS_T64 + 16'd4:   sel = SEL_T64_HI;
                OFS_IRQ:           sel = SEL_IRQ;
                OFS_CTRL:          sel = SEL_CTRL;
                OFS_PCOUNT:        sel = SEL_PCOUNT;
                OFS_LINK:          sel = SEL_LINK_LO;
                OFS_LINK + 16'd4:  sel = SEL_LINK_HI;
                OFS_PEN:           sel = SEL_PEN_LO;
                OFS_PEN + 16'd4:   sel = SEL_PEN_HI;
                default:           sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/devreg_wide.sv
module devreg_wide #(
    parameter int          W         = 64,
    parameter logic [63:0] KEEP_MASK = '1,
    parameter bit          DOUBLE    = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wdata,
    output logic [W-1:0]   value,
    output logic [W-1:0]   view
);
    localparam int HALF = W / 2;

    typedef struct packed {
        logic [HALF-1:0] shadow;
        logic [W-1:0]    val;
    } wide_st_t;

    wide_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.shadow = wdata;
        end
        if (wr_hi) begin
            st_d.val = {wdata, st_q.shadow} & KEEP_MASK[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;

    generate
        if (DOUBLE) begin : g_double
            assign view = {st_q.val[W-2:0], 1'b0};
        end else begin : g_plain
            assign view = st_q.val;
        end
    endgenerate

    AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(value)); // R4
    AST_HI_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (value[W-1:HALF] == ($past(wdata) & KEEP_MASK[W-1:HALF]))); // R4

endmodule

// File: rtl/devreg_bank.sv
module devreg_bank
    import devreg_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int VEC_W     = 8,
    parameter int NUM_PORTS = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic [63:0]       link_up,
    output logic [63:0]       port_en,
    output logic              soft_rst,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vec
);
    localparam int DATA_W = 32;
    localparam int WIDE_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] t32;
        logic [VEC_W-1:0]  vec;
        logic              irq;
        logic              rst;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } bank_st_t;

    bank_st_t st_d, st_q;

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic [WIDE_W-1:0] t64_val;
    logic [WIDE_W-1:0] t64_view;
    logic [WIDE_W-1:0] pen_val;
    logic [WIDE_W-1:0] pen_view;
    logic [WIDE_W-1:0] link_seen;
    logic [DATA_W-1:0] rd_mux;

    devreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    devreg_wide #(.W(WIDE_W), .KEEP_MASK('1), .DOUBLE(1'b1)) u_t64 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_en && (sel == SEL_T64_LO)),
        .wr_hi (wr_en && (sel == SEL_T64_HI)),
        .wdata (bus_wdata),
        .value (t64_val),
        .view  (t64_view)
    );

    devreg_wide #(.W(WIDE_W), .KEEP_MASK(PORT_LIVE_MASK), .DOUBLE(1'b0)) u_pen (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_en && (sel == SEL_PEN_LO)),
        .wr_hi (wr_en && (sel == SEL_PEN_HI)),
        .wdata (bus_wdata),
        .value (pen_val),
        .view  (pen_view)
    );

    assign link_seen = link_up & PORT_LIVE_MASK;

    always_comb begin
        unique case (sel)
            SEL_GUARD:   rd_mux = GUARD_MARK;
            SEL_T32:     rd_mux = {st_q.t32[DATA_W-2:0], 1'b0};
            SEL_T64_LO:  rd_mux = t64_view[DATA_W-1:0];
            SEL_T64_HI:  rd_mux = t64_view[WIDE_W-1:DATA_W];
            SEL_IRQ:     rd_mux = DATA_W'(st_q.vec);
            SEL_PCOUNT:  rd_mux = DATA_W'(NUM_PORTS);
            SEL_LINK_LO: rd_mux = link_seen[DATA_W-1:0];
            SEL_LINK_HI: rd_mux = link_seen[WIDE_W-1:DATA_W];
            SEL_PEN_LO:  rd_mux = pen_view[DATA_W-1:0];
            SEL_PEN_HI:  rd_mux = pen_view[WIDE_W-1:DATA_W];
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.irq    = 1'b0;
        st_d.rst    = 1'b0;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = rd_mux;
        end
        if (wr_en) begin
            unique case (sel)
                SEL_T32: st_d.t32 = bus_wdata;
                SEL_IRQ: begin
                    st_d.vec = bus_wdata[VEC_W-1:0];
                    st_d.irq = 1'b1;
                end
                SEL_CTRL: st_d.rst = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ready = 1'b1;
    assign rsp_valid = st_q.rvalid;
    assign rsp_rdata = st_q.rdata;
    assign port_en   = pen_val;
    assign soft_rst  = st_q.rst;
    assign irq_pulse = st_q.irq;
    assign irq_vec   = st_q.vec;

    AST_GUARD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (sel == SEL_GUARD)) |-> (rsp_rdata == GUARD_MARK)); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (sel == SEL_NONE)) |-> (rsp_rdata == '0)); // R2
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(wr_en && (sel == SEL_IRQ))); // R6
    AST_PORT_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en[0] && !port_en[WIDE_W-1]); // R7
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(wr_en && (sel == SEL_CTRL) && bus_wdata[0])); // R9
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_en)); // R11
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid); // R11

endmodule

// File: tb/test_devreg_bank.sv
module test_devreg_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    // link_up stays all ones while this table is walked
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 32'hDEADBABE, 4'd1},   // R1
        '{1'b1, 16'h0004, 32'h0000_1234, 4'd1},
        '{1'b0, 16'h0004, 32'hDEADBABE, 4'd1},
        '{1'b0, 16'h000C, 32'hDEADBABE, 4'd1},
        '{1'b1, 16'h0010, 32'h0000_0005, 4'd3},  // R3
        '{1'b0, 16'h0010, 32'h0000_000A, 4'd3},
        '{1'b1, 16'h0010, 32'h8000_0003, 4'd3},
        '{1'b0, 16'h0010, 32'h0000_0006, 4'd3},
        '{1'b1, 16'h0018, 32'h8000_0001, 4'd4},  // R4 lower held only
        '{1'b0, 16'h0018, 32'h0000_0000, 4'd4},
        '{1'b1, 16'h001C, 32'h0000_0002, 4'd5},  // R5
        '{1'b0, 16'h0018, 32'h0000_0002, 4'd5},
        '{1'b0, 16'h001C, 32'h0000_0005, 4'd5},
        '{1'b1, 16'h001C, 32'h8000_0000, 4'd4},  // upper alone reuses held lower
        '{1'b0, 16'h0018, 32'h0000_0002, 4'd4},
        '{1'b0, 16'h001C, 32'h0000_0001, 4'd4},
        '{1'b1, 16'h0318, 32'hFFFF_FFFF, 4'd7},  // R7
        '{1'b0, 16'h0318, 32'h0000_0000, 4'd7},
        '{1'b1, 16'h031C, 32'hFFFF_FFFF, 4'd7},
        '{1'b0, 16'h0318, 32'hFFFF_FFFE, 4'd7},
        '{1'b0, 16'h031C, 32'h7FFF_FFFF, 4'd7},
        '{1'b0, 16'h0304, 32'h0000_003E, 4'd10}, // R10
        '{1'b1, 16'h0040, 32'h0000_0005, 4'd2},  // R2
        '{1'b0, 16'h0040, 32'h0000_0000, 4'd2},
        '{1'b0, 16'h1000, 32'h0000_0000, 4'd2},
        '{1'b0, 16'h0310, 32'hFFFF_FFFE, 4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [63:0] link_up = '1;
    logic [63:0] port_en;
    logic        soft_rst;
    logic        irq_pulse;
    logic [7:0]  irq_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    devreg_bank i_devreg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .link_up   (link_up),
        .port_en   (port_en),
        .soft_rst  (soft_rst),
        .irq_pulse (irq_pulse),
        .irq_vec   (irq_vec)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a[12:0];
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a[12:0];
        @(negedge clk);
        d = rsp_rdata;
        v = rsp_valid;
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R7 R9 R6 R11
        check(port_en == 64'h0, "R7 reset port_en", port_en, 64'h0);
        check(!soft_rst && !irq_pulse, "R9 reset pulses", {soft_rst, irq_pulse}, 64'h0);
        check(!rsp_valid, "R11 reset rsp_valid", rsp_valid, 64'h0);
        check(bus_ready, "R11 bus_ready", bus_ready, 64'h1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data);
                check(!rsp_valid, $sformatf("R11 no rsp after write %0d", i), rsp_valid, 64'h0);
            end else begin
                do_read(VECS[i].addr, rd, rv);
                check(rv, $sformatf("R11 rsp_valid vec %0d", i), rv, 64'h1);
                check(rd == VECS[i].data, $sformatf("R%0d vec %0d addr %h", VECS[i].req, i, VECS[i].addr),
                      rd, VECS[i].data);
            end
        end

        // R7 enable mask on the output
        check(port_en == 64'h7FFF_FFFF_FFFF_FFFE, "R7 port_en output", port_en, 64'h7FFF_FFFF_FFFF_FFFE);
        // R1 R2 guard/unmapped writes did not disturb other state
        check(irq_vec == 8'h00 && port_en == 64'h7FFF_FFFF_FFFF_FFFE, "R2 no side effects",
              {irq_vec, port_en[55:0]}, {8'h00, 56'hFF_FFFF_FFFF_FFFE});

        // R8 with a varied link pattern
        link_up = 64'h8000_00A5_0000_0F0F;
        do_read(16'h0310, rd, rv);
        check(rd == 32'h0000_0F0E, "R8 link low", rd, 32'h0000_0F0E);
        do_read(16'h0314, rd, rv);
        check(rd == 32'h0000_00A5, "R8 link high", rd, 32'h0000_00A5);

        // R6 interrupt request
        do_write(16'h0020, 32'h0000_0117);
        check(irq_pulse && irq_vec == 8'h17, "R6 irq pulse", {irq_pulse, irq_vec}, {1'b1, 8'h17});
        @(negedge clk);
        check(!irq_pulse, "R6 irq one cycle", irq_pulse, 64'h0);
        do_read(16'h0020, rd, rv);
        check(rd == 32'h17, "R6 irq readback", rd, 32'h17);

        // R9 control word
        do_write(16'h0300, 32'h0000_0002);
        check(!soft_rst, "R9 bit0 clear no pulse", soft_rst, 64'h0);
        do_write(16'h0300, 32'h0000_0001);
        check(soft_rst, "R9 reset pulse", soft_rst, 64'h1);
        @(negedge clk);
        check(!soft_rst, "R9 pulse one cycle", soft_rst, 64'h0);
        do_read(16'h0300, rd, rv);
        check(rd == 32'h0, "R9 control reads zero", rd, 32'h0);

        // R7 edge bits after a commit of a pattern with them set
        do_write(16'h0318, 32'h0000_0003);
        do_write(16'h031C, 32'hC000_0000);
        check(port_en == 64'h4000_0000_0000_0002, "R7 edge bits dropped", port_en, 64'h4000_0000_0000_0002);

        // R5 doubling wraps at bit 63
        do_write(16'h0018, 32'hFFFF_FFFF);
        do_write(16'h001C, 32'hFFFF_FFFF);
        do_read(16'h001C, rd, rv);
        check(rd == 32'hFFFF_FFFF, "R5 high word wrap", rd, 32'hFFFF_FFFF);
        do_read(16'h0018, rd, rv);
        check(rd == 32'hFFFF_FFFE, "R5 low word wrap", rd, 32'hFFFF_FFFE);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule